// File: doc/BRIEF.md
# Reset Cause and Retention Controller

This block collects the reset requests of a small processor system and turns them into one synchronous system reset pulse of fixed length. There are four sources: the power-on reset (the block's own asynchronous reset), an external reset pin, a watchdog expiry pulse and a software request made through the register bus. Each cause that has its own flag is logged in a sticky status register. Software reads that register after a reset to learn why the system restarted. An all-zero status means the restart came from the external pin.

A key-protected configuration register holds two retention flags, one for GPIO state and one for DAC state. Whenever the system reset pulse follows a watchdog or software cause, the flags are presented on two outputs for the length of the pulse, so that those peripherals can keep their state. The block also holds the boot remap bit, which chooses SRAM or flash at address zero. Every reset returns that bit to flash.

Registers sit on a single-cycle bus with a write strobe, a 3-bit word address, 8-bit write data and combinational read data. Offsets: 0 remap, 1 cause status, 2 cause clear, 3 first key, 4 configuration, 5 second key.

Top module: `reset_manager`

## Requirements
- R1: After power-on reset (rst_ni low) the status reads 0x01, the configuration reads 0x05 and the remap bit reads 0. Both retention outputs stay low during the power-on pulse.
- R2: Every reset cause (power-on release, ext_rst_i, wdt_expire_i, software request) drives sys_rst_o high for exactly PULSE_LEN (default 4) cycles.
- R3: Status bit 0 marks power-on, bit 1 watchdog and bit 2 software. New causes are ORed into the bits already set. An external reset adds no bit, and bits [7:3] read 0.
- R4: A write to offset 1 with data bit 2 set starts a software reset. All other bits of a write to offset 1 have no effect.
- R5: Writing to offset 2 clears each status bit whose data bit is 1, so 0x07 clears all three. A cause arriving in the same cycle as the clear stays set.
- R6: The configuration changes only through three consecutive writes: 0x76 to offset 3, the value to offset 4, then 0xB1 to offset 5. Only bits 0 (GPIO) and 2 (DAC) are stored. The other bits read 0.
- R7: A wrong key value or any other bus write between the three steps aborts the sequence. The configuration then keeps its old value. A write to offset 4 outside the sequence is ignored.
- R8: gpio_keep_o and dac_keep_o are high only during sys_rst_o, and only when the cause was a watchdog or software request with no external reset in the same cycle. Each also needs its configuration bit (0 for GPIO, 2 for DAC) to be set.
- R9: Bit 0 at offset 0 is the remap bit: 1 selects SRAM and 0 selects flash, and it appears on remap_sram_o. Every reset cause clears it.
- R10: Reads of offsets 2, 3 and 5 return 0. Bus writes are ignored while sys_rst_o is high.
- R11: External, watchdog and software resets keep the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_i | input | 1 | External reset request, synchronous, active high |
| wdt_expire_i | input | 1 | Watchdog expiry, synchronous, active high |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| sys_rst_o | output | 1 | System reset pulse |
| gpio_keep_o | output | 1 | GPIO state retention during the pulse |
| dac_keep_o | output | 1 | DAC state retention during the pulse |
| remap_sram_o | output | 1 | 1: SRAM at address zero, 0: flash |

## Verification
The reset pulse is started by each of the four sources in turn, and also by watchdog and external requests together. This separates the status bit each source sets and shows which sources leave the retention outputs low. The key sequence is tried in its correct form with two different values, and then with a wrong first key, a wrong second key, a foreign write in the middle and a bare configuration write. This tells a real commit apart from each way of aborting. A clear that arrives in the same cycle as a watchdog event, and a remap write made during the pulse, test the ordering of the update paths.

// File: rtl/reset_manager_pkg.sv
package reset_manager_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_REMAP = 3'd0,
    A_CAUSE = 3'd1,
    A_CLEAR = 3'd2,
    A_KEY_A = 3'd3,
    A_CFG   = 3'd4,
    A_KEY_B = 3'd5
  } reg_addr_e;

  localparam logic [DW-1:0] KEY_A_CODE  = 8'h76;
  localparam logic [DW-1:0] KEY_B_CODE  = 8'hB1;
  localparam logic [DW-1:0] CFG_MASK    = 8'h05;
  localparam logic [DW-1:0] CFG_DEFAULT = 8'h05;
  localparam int            CFG_GPIO    = 0;
  localparam int            CFG_DAC     = 2;
  localparam int            NCAUSE      = 3;

  typedef enum logic [1:0] {KS_IDLE, KS_ARMED, KS_LOADED} key_state_e;
endpackage

// File: rtl/reset_cause_log.sv
module reset_cause_log
  import reset_manager_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_we_i,
  input  logic [NCAUSE-1:0] clr_mask_i,
  input  logic              wdt_ev_i,
  input  logic              sw_ev_i,
  output logic [NCAUSE-1:0] cause_o
);
  logic [NCAUSE-1:0] cause_q, clr_eff, set_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;
  assign set_eff = {sw_ev_i, wdt_ev_i, 1'b0};

  // a new cause wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= 3'b001;
    else         cause_q <= (cause_q & ~clr_eff) | set_eff;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/cfg_key_guard.sv
module cfg_key_guard
  import reset_manager_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] cfg_o
);
  key_state_e    state_q, state_d;
  logic [DW-1:0] pend_q, pend_d, cfg_q, cfg_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cfg_d   = cfg_q;
    if (abort_i) begin
      state_d = KS_IDLE;
      pend_d  = '0;
    end else if (wr_en_i) begin
      state_d = KS_IDLE;
      pend_d  = '0;
      unique case (state_q)
        KS_IDLE:
          if (wr_addr_i == A_KEY_A && wr_data_i == KEY_A_CODE) state_d = KS_ARMED;
        KS_ARMED:
          if (wr_addr_i == A_CFG) begin
            state_d = KS_LOADED;
            pend_d  = wr_data_i & CFG_MASK;
          end
        KS_LOADED:
          if (wr_addr_i == A_KEY_B && wr_data_i == KEY_B_CODE) cfg_d = pend_q;
        default: state_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_IDLE;
      pend_q  <= '0;
      cfg_q   <= CFG_DEFAULT;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cfg_q   <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/reset_pulse_gen.sv
module reset_pulse_gen #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic keep_cause_i,
  input  logic gpio_en_i,
  input  logic dac_en_i,
  output logic sys_rst_o,
  output logic gpio_keep_o,
  output logic dac_keep_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q;
  logic          gpio_q, dac_q;

  // power-on starts with a loaded counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LOAD;
      gpio_q <= 1'b0;
      dac_q  <= 1'b0;
    end else if (trig_i) begin
      cnt_q  <= LOAD;
      gpio_q <= keep_cause_i & gpio_en_i;
      dac_q  <= keep_cause_i & dac_en_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sys_rst_o   = (cnt_q != '0);
  assign gpio_keep_o = sys_rst_o & gpio_q;
  assign dac_keep_o  = sys_rst_o & dac_q;
endmodule

// File: rtl/reset_manager.sv
module reset_manager
  import reset_manager_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_rst_i,
  input  logic          wdt_expire_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          sys_rst_o,
  output logic          gpio_keep_o,
  output logic          dac_keep_o,
  output logic          remap_sram_o
);
  logic              wr_ok, sw_ev, any_ev, keep_cause, remap_q;
  logic [NCAUSE-1:0] cause;
  logic [DW-1:0]     cfg_q;

  assign wr_ok      = bus_we_i & ~sys_rst_o;
  assign sw_ev      = wr_ok && bus_addr_i == A_CAUSE && bus_wdata_i[2];
  assign any_ev     = ext_rst_i | wdt_expire_i | sw_ev;
  assign keep_cause = (wdt_expire_i | sw_ev) & ~ext_rst_i;

  reset_cause_log u_log (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_we_i   (wr_ok && bus_addr_i == A_CLEAR),
    .clr_mask_i (bus_wdata_i[NCAUSE-1:0]),
    .wdt_ev_i   (wdt_expire_i),
    .sw_ev_i    (sw_ev),
    .cause_o    (cause)
  );

  cfg_key_guard u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (any_ev),
    .wr_en_i   (wr_ok),
    .wr_addr_i (bus_addr_i),
    .wr_data_i (bus_wdata_i),
    .cfg_o     (cfg_q)
  );

  reset_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (any_ev),
    .keep_cause_i (keep_cause),
    .gpio_en_i    (cfg_q[CFG_GPIO]),
    .dac_en_i     (cfg_q[CFG_DAC]),
    .sys_rst_o    (sys_rst_o),
    .gpio_keep_o  (gpio_keep_o),
    .dac_keep_o   (dac_keep_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              remap_q <= 1'b0;
    else if (any_ev)                          remap_q <= 1'b0;
    else if (wr_ok && bus_addr_i == A_REMAP)  remap_q <= bus_wdata_i[0];
  end

  assign remap_sram_o = remap_q;

  always_comb begin
    unique case (bus_addr_i)
      A_REMAP: bus_rdata_o = {{(DW-1){1'b0}}, remap_q};
      A_CAUSE: bus_rdata_o = {{(DW-NCAUSE){1'b0}}, cause};
      A_CFG:   bus_rdata_o = cfg_q;
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/reset_manager_chk.sv
module reset_manager_chk
  import reset_manager_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ext_rst_i,
  input logic          wdt_expire_i,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_rdata_o,
  input logic          sys_rst_o,
  input logic          gpio_keep_o,
  input logic          dac_keep_o,
  input logic          remap_sram_o,
  input logic [DW-1:0] cfg_i
);
  a_r2_pulse_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_expire_i || ext_rst_i) |=> sys_rst_o);

  a_r8_keep_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_keep_o || dac_keep_o) |-> sys_rst_o);

  a_r8_ext_no_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (!gpio_keep_o && !dac_keep_o));

  a_r9_flash_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !remap_sram_o);

  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == A_CAUSE) |-> (bus_rdata_o[7:3] == '0));

  a_r10_wo_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == A_CLEAR || bus_addr_i == A_KEY_A || bus_addr_i == A_KEY_B)
      |-> (bus_rdata_o == '0));

  a_r11_cfg_only_by_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == A_KEY_B) |=> $stable(cfg_i));
endmodule

bind reset_manager reset_manager_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ext_rst_i    (ext_rst_i),
  .wdt_expire_i (wdt_expire_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .sys_rst_o    (sys_rst_o),
  .gpio_keep_o  (gpio_keep_o),
  .dac_keep_o   (dac_keep_o),
  .remap_sram_o (remap_sram_o),
  .cfg_i        (cfg_q)
);

// File: tb/reset_manager_test.sv
`timescale 1ns/1ps
module reset_manager_test;
  localparam int PL = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       ext_rst_i = 1'b0, wdt_expire_i = 1'b0, bus_we_i = 1'b0;
  logic [2:0] bus_addr_i = 3'd0;
  logic [7:0] bus_wdata_i = 8'h00, bus_rdata_o;
  logic       sys_rst_o, gpio_keep_o, dac_keep_o, remap_sram_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  reset_manager #(.PULSE_LEN(PL)) uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  // counts pulse cycles from the current negedge; first-sample keep flags
  task automatic measure(output int n, output logic g, output logic dk);
    n = 0;
    #1 g = gpio_keep_o; dk = dac_keep_o;
    while (sys_rst_o && n < 50) begin
      n++;
      @(negedge clk_i); #1;
    end
  endtask

  task automatic pulse_wdt(logic with_ext);
    @(negedge clk_i);
    wdt_expire_i = 1'b1; ext_rst_i = with_ext;
    @(negedge clk_i);
    wdt_expire_i = 1'b0; ext_rst_i = 1'b0;
  endtask

  task automatic keyed_cfg(logic [7:0] ka, logic [7:0] v, logic [7:0] kb);
    wr(3'd3, ka); wr(3'd4, v); wr(3'd5, kb);
  endtask

  task automatic t_power_on;
    int n; logic g, dk; logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    measure(n, g, dk);
    check("R2 power-on pulse length", 8'(n), 8'(PL));
    check("R1 no keep in power-on pulse", {6'd0, g, dk}, 8'h00);
    rd(3'd1, d); check("R1 status default", d, 8'h01);
    rd(3'd4, d); check("R1 config default", d, 8'h05);
    rd(3'd0, d); check("R1 remap default", d, 8'h00);
  endtask

  task automatic t_clear_and_ignore;
    logic [7:0] d;
    wr(3'd2, 8'h07);
    rd(3'd1, d); check("R5 clear all", d, 8'h00);
    wr(3'd1, 8'hFB);
    #1 check("R4 no reset without bit 2", {7'd0, sys_rst_o}, 8'h00);
    rd(3'd1, d); check("R4 other status bits ignored", d, 8'h00);
  endtask

  task automatic t_external;
    int n; logic g, dk; logic [7:0] d;
    @(negedge clk_i); ext_rst_i = 1'b1;
    @(negedge clk_i); ext_rst_i = 1'b0;
    measure(n, g, dk);
    check("R2 external pulse length", 8'(n), 8'(PL));
    check("R8 no keep on external", {6'd0, g, dk}, 8'h00);
    rd(3'd1, d); check("R3 external leaves status zero", d, 8'h00);
    rd(3'd4, d); check("R11 config kept on external", d, 8'h05);
  endtask

  task automatic t_software;
    int n; logic g, dk; logic [7:0] d;
    wr(3'd0, 8'h01);
    rd(3'd0, d); check("R9 remap readback", d, 8'h01);
    check("R9 remap output", {7'd0, remap_sram_o}, 8'h01);
    wr(3'd1, 8'h04);
    measure(n, g, dk);
    check("R2 software pulse length", 8'(n), 8'(PL));
    check("R8 both keep on software cfg 05", {6'd0, g, dk}, 8'h03);
    check("R9 remap cleared by reset", {7'd0, remap_sram_o}, 8'h00);
    rd(3'd1, d); check("R3 software bit", d, 8'h04);
  endtask

  task automatic t_watchdog;
    int n; logic g, dk; logic [7:0] d;
    pulse_wdt(1'b0);
    measure(n, g, dk);
    check("R2 watchdog pulse length", 8'(n), 8'(PL));
    rd(3'd1, d); check("R3 sticky OR of causes", d, 8'h06);
    wr(3'd2, 8'h04);
    rd(3'd1, d); check("R5 clear one bit", d, 8'h02);
  endtask

  task automatic t_keyed;
    int n; logic g, dk; logic [7:0] d;
    keyed_cfg(8'h76, 8'h01, 8'hB1);
    rd(3'd4, d); check("R6 commit gpio only", d, 8'h01);
    pulse_wdt(1'b0);
    measure(n, g, dk);
    check("R8 gpio keep only", {6'd0, g, dk}, 8'h02);
    rd(3'd4, d); check("R11 config kept on watchdog", d, 8'h01);
    keyed_cfg(8'h76, 8'hFE, 8'hB1);
    rd(3'd4, d); check("R6 masked commit", d, 8'h04);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    keyed_cfg(8'h77, 8'h05, 8'hB1);
    rd(3'd4, d); check("R7 wrong first key", d, 8'h04);
    keyed_cfg(8'h76, 8'h05, 8'hB0);
    rd(3'd4, d); check("R7 wrong second key", d, 8'h04);
    wr(3'd3, 8'h76); wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd5, 8'hB1);
    rd(3'd4, d); check("R7 foreign write aborts", d, 8'h04);
    wr(3'd4, 8'h05);
    rd(3'd4, d); check("R7 bare config write", d, 8'h04);
  endtask

  task automatic t_misc;
    int n; logic g, dk; logic [7:0] d;
    rd(3'd2, d); check("R10 clear reads zero", d, 8'h00);
    rd(3'd3, d); check("R10 key A reads zero", d, 8'h00);
    rd(3'd5, d); check("R10 key B reads zero", d, 8'h00);
    pulse_wdt(1'b1);
    wr(3'd0, 8'h01);
    measure(n, g, dk);
    check("R8 watchdog with external: no keep", {6'd0, g, dk}, 8'h00);
    rd(3'd0, d); check("R10 write in pulse ignored", d, 8'h00);
    // clear of bit 1 coincides with a new watchdog event
    wr(3'd2, 8'h07);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = 3'd2; bus_wdata_i = 8'h02; wdt_expire_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0; wdt_expire_i = 1'b0;
    measure(n, g, dk);
    rd(3'd1, d); check("R5 new cause beats clear", d, 8'h02);
    check("R3 reserved bits zero", d & 8'hF8, 8'h00);
  endtask

  initial begin
    t_power_on();
    t_clear_and_ignore();
    t_external();
    t_software();
    t_watchdog();
    t_keyed();
    t_abort();
    t_misc();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule